// File: doc/BRIEF.md
# Valid/Ready Pipeline Stage with Skid Register

This block is one registered stage of a valid/ready pipeline. It takes words from an upstream producer and hands them to a downstream consumer. A word crosses either interface only in a cycle where that side's valid and ready are both high. The ready signal sent upstream is a promise: once it is high, the stage must accept any valid word offered in that cycle. It comes straight from a flip-flop, so a stall seen downstream cannot reach the upstream producer combinationally in the same clock.

The parameter `FULL_RATE` picks one of two forms. With `FULL_RATE=1` the stage has a main register and a skid register. The skid register catches the word that arrives in the cycle a downstream stall is first felt. This lets the stage move one word every clock and still stop locally without losing data. With `FULL_RATE=0` the stage has a single register and raises ready only when that register is empty. This form costs half the storage, but at best it moves one word every two clocks.

Top module: `flow_stage`

## Requirements
- R1: A synchronous reset empties the stage. In the cycle after a reset edge, `dnValid` is 0, `upReady` is 1 and `dnData` is 0.
- R2: Words leave through `dnData` in exactly the order they were accepted. An upstream word is accepted when `upValid` and `upReady` are both high at a clock edge. A downstream word is delivered when `dnValid` and `dnReady` are both high. No word is dropped, duplicated or invented, whatever the stall pattern.
- R3: While `dnValid` is high and `dnReady` is low at an edge, `dnValid` stays high and `dnData` keeps its value in the following cycle.
- R4: With `FULL_RATE=1`, `upValid` held high and `dnReady` held high, the stage accepts a word at every clock edge. A word accepted at an edge is presented on `dnData` right after that edge.
- R5: With `FULL_RATE=1`, the skid register fills when a word is accepted while the held word is stalled. In that case `upReady` is low in the next cycle. Once downstream takes a word while `upReady` is low, `upReady` is high again in the next cycle.
- R6: With `FULL_RATE=0`, `upReady` is high only in cycles where `dnValid` is low.
- R7: `upReady` depends on no input combinationally. Changing `dnReady` inside a cycle leaves `upReady` unchanged until the next clock edge.
- R8: With `FULL_RATE=0`, `upValid` high and `dnReady` high, the stage accepts exactly one word every two clock edges.
- R9: A reset asserted while the stage holds words discards them. After the reset, the stage delivers only words accepted after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| upData | input | WIDTH | Word offered by the upstream producer |
| upValid | input | 1 | Upstream word is valid |
| upReady | output | 1 | Stage accepts a word this cycle (registered) |
| dnData | output | WIDTH | Word presented to the downstream consumer |
| dnValid | output | 1 | `dnData` holds a word |
| dnReady | input | 1 | Downstream takes the presented word this cycle |

## Verification
Every result of this stage is due one clock edge after the stimulus that causes it. An accepted word shows on `dnData` after the accepting edge. `upReady` falls one edge after a word is parked in the skid register, and rises one edge after downstream takes a word while `upReady` is low. The bench drives inputs just after the falling edge and records handshakes 1 ns later, so both sides of every transfer are taken from the values present at the next rising edge. Outputs are compared at the following falling edge against a queue-based reference model and against counts worked out from the requirements. R7 is checked by changing `dnReady` in the middle of a cycle and reading `upReady` again before any edge.

// File: rtl/flow_stage_pkg.sv
package flow_stage_pkg;

  // Strobes from the occupancy control to the word registers.
  typedef struct packed {
    logic takeIn;   // main register loads the upstream word
    logic park;     // skid register loads the upstream word
    logic promote;  // main register loads the skid word
  } stageCtl_t;

endpackage

// File: rtl/stage_ctrl.sv
module stage_ctrl
  import flow_stage_pkg::*;
#(
  parameter int unsigned FULL_RATE = 1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      upValid,
  input  logic      dnReady,
  output logic      upReady,
  output logic      dnValid,
  output stageCtl_t strb
);

  generate
    if (FULL_RATE != 0) begin : g_skid
      logic mainFull;
      logic skidFull;
      logic acceptUp;
      logic sendDn;

      always_comb begin
        acceptUp = upValid & ~skidFull;
        sendDn   = mainFull & dnReady;
        strb     = '0;
        if (skidFull) begin
          strb.promote = sendDn;
        end else if (acceptUp) begin
          if (mainFull && !sendDn) strb.park   = 1'b1;
          else                     strb.takeIn = 1'b1;
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          mainFull <= 1'b0;
          skidFull <= 1'b0;
        end else if (skidFull) begin
          // main stays occupied: either its word stays or the skid word moves in
          if (sendDn) skidFull <= 1'b0;
        end else begin
          skidFull <= acceptUp & mainFull & ~dnReady;
          mainFull <= acceptUp | (mainFull & ~dnReady);
        end
      end

      assign upReady = ~skidFull;
      assign dnValid = mainFull;
    end else begin : g_single
      logic mainFull;

      always_comb begin
        strb        = '0;
        strb.takeIn = upValid & ~mainFull;
      end

      always_ff @(posedge clk) begin
        if (rst)           mainFull <= 1'b0;
        else if (mainFull) mainFull <= ~dnReady;
        else               mainFull <= upValid;
      end

      assign upReady = ~mainFull;
      assign dnValid = mainFull;
    end
  endgenerate

endmodule

// File: rtl/stage_data.sv
module stage_data
  import flow_stage_pkg::*;
#(
  parameter int unsigned WIDTH     = 32,
  parameter int unsigned FULL_RATE = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  stageCtl_t        strb,
  input  logic [WIDTH-1:0] upData,
  output logic [WIDTH-1:0] dnData
);

  logic [WIDTH-1:0] mainWord;

  generate
    if (FULL_RATE != 0) begin : g_skid
      logic [WIDTH-1:0] skidWord;

      always_ff @(posedge clk) begin
        if (rst) begin
          mainWord <= '0;
          skidWord <= '0;
        end else begin
          if (strb.takeIn)       mainWord <= upData;
          else if (strb.promote) mainWord <= skidWord;
          if (strb.park)         skidWord <= upData;
        end
      end
    end else begin : g_single
      logic unusedStrobes;
      assign unusedStrobes = strb.park ^ strb.promote;

      always_ff @(posedge clk) begin
        if (rst)              mainWord <= '0;
        else if (strb.takeIn) mainWord <= upData;
      end
    end
  endgenerate

  assign dnData = mainWord;

endmodule

// File: rtl/flow_stage.sv
module flow_stage
  import flow_stage_pkg::*;
#(
  parameter int unsigned WIDTH     = 32,
  parameter int unsigned FULL_RATE = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] upData,
  input  logic             upValid,
  output logic             upReady,
  output logic [WIDTH-1:0] dnData,
  output logic             dnValid,
  input  logic             dnReady
);

  stageCtl_t ctlStrb;

  stage_ctrl #(
    .FULL_RATE(FULL_RATE)
  ) uCtrl (
    .clk    (clk),
    .rst    (rst),
    .upValid(upValid),
    .dnReady(dnReady),
    .upReady(upReady),
    .dnValid(dnValid),
    .strb   (ctlStrb)
  );

  stage_data #(
    .WIDTH    (WIDTH),
    .FULL_RATE(FULL_RATE)
  ) uData (
    .clk   (clk),
    .rst   (rst),
    .strb  (ctlStrb),
    .upData(upData),
    .dnData(dnData)
  );

endmodule

// File: rtl/stage_checker.sv
module stage_checker #(
  parameter int unsigned WIDTH     = 32,
  parameter int unsigned FULL_RATE = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             upValid,
  input logic             upReady,
  input logic [WIDTH-1:0] dnData,
  input logic             dnValid,
  input logic             dnReady
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!dnValid && upReady && dnData == '0));

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (dnValid && !dnReady) |=> (dnValid && $stable(dnData)));

  // R2
  accept_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (upValid && upReady) |=> dnValid);

  generate
    if (FULL_RATE != 0) begin : g_skid
      // R5
      ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (upValid && upReady && dnValid && !dnReady) |=> !upReady);

      // R5
      ready_back_chk: assert property (@(posedge clk) disable iff (rst)
        (!upReady && dnValid && dnReady) |=> upReady);

      // R4
      full_rate_chk: assert property (@(posedge clk) disable iff (rst)
        (upReady && dnReady) |=> upReady);
    end else begin : g_single
      // R6
      single_empty_chk: assert property (@(posedge clk) disable iff (rst)
        upReady |-> !dnValid);
    end
  endgenerate

endmodule

bind flow_stage stage_checker #(
  .WIDTH    (WIDTH),
  .FULL_RATE(FULL_RATE)
) uChk (
  .clk    (clk),
  .rst    (rst),
  .upValid(upValid),
  .upReady(upReady),
  .dnData (dnData),
  .dnValid(dnValid),
  .dnReady(dnReady)
);

// File: tb/sim_flow_stage.sv
`timescale 1ns/1ps
module sim_flow_stage;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] upData;
  logic         upValid;
  logic         dnReady;
  logic         aRdy, aVal, bRdy, bVal;
  logic [W-1:0] aOut, bOut;

  int nChecks = 0;
  int nBad    = 0;
  bit finished = 0;
  int seqN = 0;
  int accA = 0, accB = 0;
  bit stallA = 0, stallB = 0;
  logic [W-1:0] holdA, holdB;
  logic [W-1:0] qA[$];
  logic [W-1:0] qB[$];

  always #2.5 clk = ~clk;

  flow_stage #(.WIDTH(W), .FULL_RATE(1)) u0 (
    .clk(clk), .rst(rst), .upData(upData), .upValid(upValid), .upReady(aRdy),
    .dnData(aOut), .dnValid(aVal), .dnReady(dnReady));

  flow_stage #(.WIDTH(W), .FULL_RATE(0)) u1 (
    .clk(clk), .rst(rst), .upData(upData), .upValid(upValid), .upReady(bRdy),
    .dnData(bOut), .dnValid(bVal), .dnReady(dnReady));

  function automatic logic [W-1:0] wordFor(input int n);
    return W'((n * 40503) ^ 23130);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input bit v, input bit r);
    upValid = v;
    dnReady = r;
    upData  = wordFor(seqN);
    seqN++;
  endtask

  // Records handshakes seen by the next rising edge, then waits for the falling edge.
  task automatic cycle();
    logic [W-1:0] e;
    #1;
    if (!rst) begin
      if (stallA) check(aVal && aOut == holdA, "R3 skid variant hold", aOut, holdA);
      if (stallB) check(bVal && bOut == holdB, "R3 single variant hold", bOut, holdB);
      if (upValid && aRdy) begin qA.push_back(upData); accA++; end
      if (upValid && bRdy) begin qB.push_back(upData); accB++; end
      if (aVal && dnReady) begin
        if (qA.size() == 0) check(1'b0, "R2 skid variant spurious word", aOut, 0);
        else begin e = qA.pop_front(); check(aOut == e, "R2 skid variant order", aOut, e); end
      end
      if (bVal && dnReady) begin
        if (qB.size() == 0) check(1'b0, "R2 single variant spurious word", bOut, 0);
        else begin e = qB.pop_front(); check(bOut == e, "R2 single variant order", bOut, e); end
      end
      stallA = aVal && !dnReady; holdA = aOut;
      stallB = bVal && !dnReady; holdB = bOut;
    end else begin
      stallA = 0;
      stallB = 0;
    end
    @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nBad++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 150000, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int a0, b0, pv, pr;
    void'($urandom(1234));
    rst = 1'b1; upValid = 1'b0; dnReady = 1'b0; upData = '0;
    repeat (3) @(negedge clk);
    // R1 reset state of both variants
    check(!aVal && aRdy && aOut == '0, "R1 skid variant reset", {aVal, aRdy}, 1);
    check(!bVal && bRdy && bOut == '0, "R1 single variant reset", {bVal, bRdy}, 1);
    rst = 1'b0;

    // R4 / R8: both sides always willing for 20 edges
    a0 = accA; b0 = accB;
    for (int i = 0; i < 20; i++) begin
      drive(1, 1);
      if (i > 0) check(aRdy, "R4 ready held high", aRdy, 1);
      cycle();
      if (i == 0) check(aVal && aOut == wordFor(seqN - 1), "R4 one-edge latency", aOut, wordFor(seqN - 1));
    end
    check(accA - a0 == 20, "R4 skid variant accepts per edge", accA - a0, 20);
    check(accB - b0 == 10, "R8 single variant half rate", accB - b0, 10);
    for (int i = 0; i < 4; i++) begin drive(0, 1); cycle(); end

    // R5 / R7: fill main and skid, then release
    drive(1, 0); cycle();
    check(aRdy, "R5 skid still free", aRdy, 1);
    drive(1, 0); cycle();
    check(!aRdy, "R5 ready drops when skid fills", aRdy, 0);
    check(!bRdy && bVal, "R6 single variant busy", bRdy, 0);
    drive(0, 0);
    #0.5 dnReady = 1'b1;
    #0.2 check(!aRdy, "R7 no path from dnReady", aRdy, 0);
    cycle();
    check(aRdy && aVal, "R5 ready returns after drain", aRdy, 1);
    for (int i = 0; i < 4; i++) begin drive(0, 1); cycle(); end

    // R9: reset with words held
    drive(1, 0); cycle();
    drive(1, 0); cycle();
    rst = 1'b1; drive(0, 0); cycle();
    check(!aVal && aRdy, "R9 skid variant emptied", aVal, 0);
    check(!bVal && bRdy, "R9 single variant emptied", bVal, 0);
    qA.delete(); qB.delete();
    rst = 1'b0;
    drive(1, 1); cycle();
    check(aVal && aOut == wordFor(seqN - 1), "R9 first word after reset", aOut, wordFor(seqN - 1));

    // Random phases with varying offer and accept rates
    for (int ph = 0; ph < 10; ph++) begin
      pv = $urandom_range(100, 20);
      pr = $urandom_range(100, 10);
      for (int i = 0; i < 300; i++) begin
        drive(($urandom % 100) < pv, ($urandom % 100) < pr);
        if (!bRdy) check(bVal, "R6 ready only when empty", bVal, 1);
        cycle();
      end
    end

    for (int i = 0; i < 8; i++) begin drive(0, 1); cycle(); end
    check(qA.size() == 0 && !aVal, "R2 skid variant drained", qA.size(), 0);
    check(qB.size() == 0 && !bVal, "R2 single variant drained", qB.size(), 0);

    summary();
    $finish;
  end

endmodule